// File: doc/BRIEF.md
# Floating-Point Compare Condition Queue

This block keeps the compare-result portion of a 32-bit floating-point status word. When a compare finishes, an external comparator presents a one-hot relation (greater, less, equal or unordered) together with a 5-bit condition mask and a 4-bit selector. The block picks one outcome bit from the mask according to the relation. It then either overwrites one indexed condition bit or pushes the outcome onto a short history queue held inside the status word.

The selector picks the mode. A value from 1 to 11 writes a single bit. Zero pushes the outcome into the queue head, and the previous head and queue entries each move one place down. The block also returns a registered flag that tells the comparator whether the compare was signaling, so that the comparator can raise its invalid exception on unordered operands. A load port lets the owner of the status word replace it as a whole. An update that arrives in the same cycle is applied on top of the loaded value.

Top module: `fcmp_cond_queue`

## Requirements
- R1: The outcome bit is taken from the condition mask by relation. The relation input uses bit 3 for greater, bit 2 for less, bit 1 for equal and bit 0 for unordered. These select mask bit 4, 3, 2 and 1 respectively.
- R2: An accepted update with selector y in 1..11 writes the outcome into status bit 22-y. Every other bit keeps its value.
- R3: An accepted update with selector 0 moves status bits 21:12 into bits 20:11, and the old bit 11 is dropped.
- R4: An accepted update with selector 0 copies the old bit 26 into bit 21 and writes the outcome into bit 26.
- R5: `sig_o` is 1 for exactly the cycle after an accepted update whose mask bit 0 is 1. It is 0 at all other times.
- R6: An update with selector above 11 leaves the status word unchanged and pulses `err_o` in the following cycle.
- R7: An update whose relation input is not exactly one-hot leaves the status word unchanged and pulses `err_o` in the following cycle.
- R8: The new status word appears on `status_q` in the cycle after the strobe. With no strobe and no load, `status_q` holds its value.
- R9: A synchronous active-high reset clears `status_q`, `sig_o` and `err_o`.
- R10: `ld_en` replaces the status word with `ld_data` in the next cycle. An accepted update in the same cycle is applied to `ld_data`, not to the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Compare-result update strobe |
| rel_onehot | input | 4 | Relation: [3] greater, [2] less, [1] equal, [0] unordered |
| cond_mask | input | 5 | Condition mask; [0] selects signaling compare |
| sel_y | input | 4 | 0 = queue push, 1..11 = indexed bit write |
| ld_en | input | 1 | Whole-word load strobe |
| ld_data | input | 32 | Word to load |
| status_q | output | 32 | Registered status word |
| sig_o | output | 1 | Registered signaling indication for the last update |
| err_o | output | 1 | Registered error pulse for a rejected update |

## Verification
A whole-word load and a compare update can fall in the same cycle. In that case the update must modify the loaded word, and a rejected update must not disturb the load. The bench provokes this with loads carrying indexed writes and queue pushes, and with loads carrying bad selectors or bad relations. It judges the result against a reference model that forms the next word from the load data first. A bad selector combined with a bad relation in one strobe is also driven, and it must give a single error pulse.

// File: rtl/fcq_pkg.sv
package fcq_pkg;
  localparam int REL_N  = 4;
  localparam int MASK_W = REL_N + 1;
  localparam int SIG_BIT = 0;

  typedef struct packed {
    logic accept;
    logic outcome;
    logic signaling;
  } fcq_pick_t;
endpackage

// File: rtl/fcq_pick.sv
module fcq_pick
  import fcq_pkg::*;
(
  input  logic [REL_N-1:0]  rel,
  input  logic [MASK_W-1:0] mask,
  output fcq_pick_t         pick
);
  logic [REL_N-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < REL_N; i++) begin : g_rel
      assign hit[i] = rel[i] & mask[i+1];
    end
  endgenerate

  always_comb begin
    pick.accept    = ($countones(rel) == 1);
    pick.outcome   = |hit;
    pick.signaling = mask[SIG_BIT];
  end
endmodule

// File: rtl/fcq_ydec.sv
module fcq_ydec #(
  parameter int SW      = 32,
  parameter int YW      = 4,
  parameter int Y_MAX   = 11,
  parameter int IDX_TOP = 21
) (
  input  logic [YW-1:0] sel_y,
  output logic [SW-1:0] tgt,
  output logic          y_ok,
  output logic          push
);
  localparam int Q_LO = IDX_TOP - Y_MAX + 1;
  localparam logic [YW-1:0] Y_LIM = YW'(Y_MAX);

  genvar b;
  generate
    for (b = 0; b < SW; b++) begin : g_bit
      if (b >= Q_LO && b <= IDX_TOP) begin : g_sel
        assign tgt[b] = (sel_y == YW'(IDX_TOP + 1 - b));
      end else begin : g_none
        assign tgt[b] = 1'b0;
      end
    end
  endgenerate

  assign y_ok = (sel_y <= Y_LIM);
  assign push = (sel_y == '0);
endmodule

// File: rtl/fcq_next.sv
module fcq_next #(
  parameter int SW       = 32,
  parameter int Y_MAX    = 11,
  parameter int IDX_TOP  = 21,
  parameter int HEAD_BIT = 26
) (
  input  logic [SW-1:0] cur,
  input  logic [SW-1:0] tgt,
  input  logic          apply,
  input  logic          push,
  input  logic          outcome,
  output logic [SW-1:0] nxt
);
  localparam int Q_LO = IDX_TOP - Y_MAX + 1;

  logic [SW-1:0] pushed;
  logic [SW-1:0] indexed;

  genvar b;
  generate
    for (b = 0; b < SW; b++) begin : g_bit
      if (b == HEAD_BIT) begin : g_head
        assign pushed[b] = outcome;
      end else if (b == IDX_TOP) begin : g_tail_in
        assign pushed[b] = cur[HEAD_BIT];
      end else if (b >= Q_LO && b < IDX_TOP) begin : g_shift
        assign pushed[b] = cur[b+1];
      end else begin : g_keep
        assign pushed[b] = cur[b];
      end
      assign indexed[b] = tgt[b] ? outcome : cur[b];
    end
  endgenerate

  always_comb begin
    if (!apply)    nxt = cur;
    else if (push) nxt = pushed;
    else           nxt = indexed;
  end
endmodule

// File: rtl/fcmp_cond_queue.sv
module fcmp_cond_queue
  import fcq_pkg::*;
#(
  parameter int SW       = 32,
  parameter int YW       = 4,
  parameter int Y_MAX    = 11,
  parameter int IDX_TOP  = 21,
  parameter int HEAD_BIT = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic [REL_N-1:0]  rel_onehot,
  input  logic [MASK_W-1:0] cond_mask,
  input  logic [YW-1:0]     sel_y,
  input  logic              ld_en,
  input  logic [SW-1:0]     ld_data,
  output logic [SW-1:0]     status_q,
  output logic              sig_o,
  output logic              err_o
);
  fcq_pick_t     pick;
  logic [SW-1:0] tgt;
  logic          y_ok;
  logic          push;
  logic          apply;
  logic [SW-1:0] base;
  logic [SW-1:0] nxt;

  fcq_pick u_pick (
    .rel  (rel_onehot),
    .mask (cond_mask),
    .pick (pick)
  );

  fcq_ydec #(.SW(SW), .YW(YW), .Y_MAX(Y_MAX), .IDX_TOP(IDX_TOP)) u_ydec (
    .sel_y (sel_y),
    .tgt   (tgt),
    .y_ok  (y_ok),
    .push  (push)
  );

  assign apply = upd_valid & pick.accept & y_ok;
  assign base  = ld_en ? ld_data : status_q;

  fcq_next #(.SW(SW), .Y_MAX(Y_MAX), .IDX_TOP(IDX_TOP), .HEAD_BIT(HEAD_BIT)) u_next (
    .cur     (base),
    .tgt     (tgt),
    .apply   (apply),
    .push    (push),
    .outcome (pick.outcome),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      sig_o    <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      status_q <= nxt;
      sig_o    <= apply & pick.signaling;
      err_o    <= upd_valid & ~(pick.accept & y_ok);
    end
  end
endmodule

// File: rtl/fcq_checker.sv
module fcq_checker #(
  parameter int SW       = 32,
  parameter int YW       = 4,
  parameter int Y_MAX    = 11,
  parameter int IDX_TOP  = 21,
  parameter int HEAD_BIT = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_valid,
  input logic [3:0]    rel_onehot,
  input logic [4:0]    cond_mask,
  input logic [YW-1:0] sel_y,
  input logic          ld_en,
  input logic [SW-1:0] status_q,
  input logic          sig_o,
  input logic          err_o
);
  localparam int Q_LO = IDX_TOP - Y_MAX + 1;
  localparam logic [YW-1:0] Y_LIM = YW'(Y_MAX);

  logic bad_y, bad_rel, good;
  assign bad_y   = upd_valid && (sel_y > Y_LIM);
  assign bad_rel = upd_valid && ($countones(rel_onehot) != 1);
  assign good    = upd_valid && !bad_y && !bad_rel;

  assert_bad_y_err_R6: assert property (@(posedge clk) disable iff (rst)
    bad_y |=> err_o);
  assert_bad_y_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bad_y && !ld_en) |=> $stable(status_q));
  assert_bad_rel_err_R7: assert property (@(posedge clk) disable iff (rst)
    bad_rel |=> (err_o && !sig_o));
  assert_bad_rel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bad_rel && !ld_en) |=> $stable(status_q));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && !ld_en) |=> ($stable(status_q) && !err_o && !sig_o));
  assert_push_tail_R4: assert property (@(posedge clk) disable iff (rst)
    (good && sel_y == '0 && !ld_en) |=> (status_q[IDX_TOP] == $past(status_q[HEAD_BIT])));
  assert_push_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (good && sel_y == '0 && !ld_en) |=> (status_q[IDX_TOP-1:Q_LO] == $past(status_q[IDX_TOP:Q_LO+1])));
  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !cond_mask[0]) |=> !sig_o);
  assert_good_no_err_R6: assert property (@(posedge clk) disable iff (rst)
    good |=> !err_o);
endmodule

bind fcmp_cond_queue fcq_checker #(
  .SW(SW), .YW(YW), .Y_MAX(Y_MAX), .IDX_TOP(IDX_TOP), .HEAD_BIT(HEAD_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_valid  (upd_valid),
  .rel_onehot (rel_onehot),
  .cond_mask  (cond_mask),
  .sel_y      (sel_y),
  .ld_en      (ld_en),
  .status_q   (status_q),
  .sig_o      (sig_o),
  .err_o      (err_o)
);

// File: tb/sim_fcmp_cond_queue.sv
module sim_fcmp_cond_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [3:0]  rel_onehot = '0;
  logic [4:0]  cond_mask = '0;
  logic [3:0]  sel_y = '0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] status_q;
  logic        sig_o, err_o;

  int checks = 0;
  int failures = 0;
  string tag_in = "R9";
  string tag_chk = "R9";
  logic [31:0] m_stat = '0;
  logic        m_sig = 1'b0, m_err = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  fcmp_cond_queue u0 (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .rel_onehot(rel_onehot),
    .cond_mask(cond_mask), .sel_y(sel_y), .ld_en(ld_en), .ld_data(ld_data),
    .status_q(status_q), .sig_o(sig_o), .err_o(err_o)
  );

  // Reference model: behaviour taken from the requirements
  always @(posedge clk) begin
    logic [31:0] w;
    logic        o;
    int          ones;
    tag_chk <= tag_in;
    if (rst) begin
      m_stat <= '0; m_sig <= 1'b0; m_err <= 1'b0;
    end else begin
      w = ld_en ? ld_data : m_stat;                     // R10
      ones = 0;
      for (int k = 0; k < 4; k++) if (rel_onehot[k]) ones++;
      m_sig <= 1'b0;
      m_err <= 1'b0;
      if (upd_valid) begin
        if (ones != 1 || sel_y > 4'd11) m_err <= 1'b1;  // R6 R7
        else begin
          case (rel_onehot)                             // R1
            4'b1000: o = cond_mask[4];
            4'b0100: o = cond_mask[3];
            4'b0010: o = cond_mask[2];
            default: o = cond_mask[1];
          endcase
          if (sel_y == 0) begin                         // R3 R4
            logic [31:0] old;
            old = w;
            for (int k = 11; k <= 20; k++) w[k] = old[k+1];
            w[21] = old[26];
            w[26] = o;
          end else w[22 - sel_y] = o;                   // R2
          m_sig <= cond_mask[0];                        // R5
        end
      end
      m_stat <= w;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 3;
      if (status_q !== m_stat) begin
        failures++;
        $display("FAIL %s status actual=%h expected=%h", tag_chk, status_q, m_stat);
      end
      if (sig_o !== m_sig) begin
        failures++;
        $display("FAIL %s sig actual=%b expected=%b", tag_chk, sig_o, m_sig);
      end
      if (err_o !== m_err) begin
        failures++;
        $display("FAIL %s err actual=%b expected=%b", tag_chk, err_o, m_err);
      end
    end
  end

  task automatic op(input string t, input logic ld, input logic [31:0] ldd,
                    input logic up, input logic [3:0] r, input logic [4:0] m,
                    input logic [3:0] y);
    tag_in = t; ld_en = ld; ld_data = ldd; upd_valid = up;
    rel_onehot = r; cond_mask = m; sel_y = y;
    @(posedge clk); #2;
    ld_en = 1'b0; upd_valid = 1'b0; tag_in = "R8";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk); #2;
    tag_in = "R9"; rst = 1'b0;
    @(posedge clk); #2;
    // R9 checked on the first compare after reset
    op("R10", 1, 32'hA5A5_3C0F, 0, 4'b0000, 5'h00, 4'd0);
    for (int y = 1; y <= 11; y++) begin
      op("R2", 0, 0, 1, 4'b0010, 5'b00100, 4'(y));
      op("R2", 0, 0, 1, 4'b1000, 5'b01110, 4'(y));
    end
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 32; m += 3)
        op("R1", 0, 0, 1, 4'(1 << r), 5'(m), 4'(r + 3));
    op("R10", 1, 32'h0400_0000, 0, 4'b0000, 5'h00, 4'd0);
    for (int k = 0; k < 14; k++)
      op("R3", 0, 0, 1, (k % 2) ? 4'b0001 : 4'b0100, 5'b01010, 4'd0);
    op("R4", 1, 32'hFBFF_FFFF, 1, 4'b1000, 5'b10000, 4'd0);
    op("R4", 0, 0, 1, 4'b0001, 5'b00000, 4'd0);
    op("R5", 0, 0, 1, 4'b0010, 5'b00101, 4'd5);
    op("R5", 0, 0, 1, 4'b0010, 5'b00100, 4'd5);
    op("R6", 0, 0, 1, 4'b1000, 5'b11111, 4'd12);
    op("R6", 0, 0, 1, 4'b0100, 5'b11111, 4'd15);
    op("R7", 0, 0, 1, 4'b0000, 5'b11111, 4'd3);
    op("R7", 0, 0, 1, 4'b0011, 5'b11111, 4'd0);
    op("R7", 0, 0, 1, 4'b1111, 5'b11111, 4'd12);
    repeat (4) @(posedge clk); #2;                       // R8 idle hold
    op("R10", 1, 32'h1234_5678, 1, 4'b0100, 5'b01001, 4'd7);
    op("R10", 1, 32'h8765_4321, 1, 4'b0001, 5'b00011, 4'd0);
    op("R10", 1, 32'hFFFF_0000, 1, 4'b1000, 5'b11111, 4'd13);
    op("R10", 1, 32'h0000_FFFF, 1, 4'b1100, 5'b11111, 4'd2);
    op("R8", 0, 0, 1, 4'b0010, 5'b00100, 4'd1);
    op("R8", 0, 0, 1, 4'b0010, 5'b00000, 4'd1);
    lf = 32'hACE1_0001;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op("R1", lf[3:0] == 4'h0, {lf[15:0], lf[31:16]}, lf[4] | lf[5],
         (lf[6] && lf[7]) ? lf[11:8] : 4'(1 << lf[9:8]), lf[16:12],
         lf[20] ? lf[24:21] : {2'b00, lf[22:21]});
    end
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule